// File: doc/BRIEF.md
# Boundary Scan Register with Pin Override

This block is the boundary scan register that sits between a core and its I/O pads. Every bidirectional pad owns three one-bit scan stages. The first takes the core's output value, the second takes the core's output enable, and the third takes the value seen at the pad's input buffer. Pads that are input-only own a single stage, which takes the pad input. All stages are joined into one serial path, so a test access port controller can snapshot the pins, shift the snapshot out, and shift a new pattern in.

Each bidirectional pad also owns two holding latches, one for output value and one for output enable. They load from the first two scan stages when the update strobe fires and stay put while the chain shifts. A two-bit mode input selects among three behaviours:
- External test: the pads take their value and enable from the holding latches.
- High impedance: every pad enable is forced off.
- Any other mode: the core's signals reach the pads unchanged.

The controller that drives the strobes and the mode decides which instruction is active. This block only follows those signals.

Top module: `bsc_chain`

## Requirements
- R1: With `rst` high at a clock edge, every scan stage and every holding latch clears to 0. After reset `tdo_o` reads 0, and in external test mode the pad outputs read value 0 with enable 0.
- R2: A clock edge with `cap_en` high loads the stages for bidirectional pad k with `core_d_i[k]`, `core_oe_i[k]` and `pin_in_i[k]`. It loads the stage for input-only pad j with `pin_in_i[NB+j]`.
- R3: A clock edge with `shift_en` high (and `cap_en` low) moves every stage one place toward `tdo_o`, and `tdi_i` enters the first stage. The chain holds 3*NB+NI stages. The order from `tdi_i` is: for pad 0 up to pad NB-1, the output value stage, then the enable stage, then the input stage; after those come the input-only stages, pad NB first. `tdo_o` shows the last stage.
- R4: A clock edge with `upd_en` high copies each pad's output value stage and enable stage into its holding latches. Capture and shift leave the latches unchanged.
- R5: With `mode_i` = 2'b01 (external test), `pin_d_o[k]` and `pin_oe_o[k]` equal pad k's holding latches.
- R6: With `mode_i` = 2'b10 (high impedance), every bit of `pin_oe_o` is 0.
- R7: With `mode_i` = 2'b00 or 2'b11, `pin_d_o` equals `core_d_i` and `pin_oe_o` equals `core_oe_i`, whatever the holding latches contain.
- R8: A clock edge with `cap_en` and `shift_en` both low leaves every stage unchanged, whatever the other inputs do.
- R9: When `cap_en` and `shift_en` are both high at a clock edge, the capture takes place and the shift does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe for holding latches |
| mode_i | input | 2 | 00/11 functional, 01 external test, 10 high impedance |
| tdi_i | input | 1 | Serial scan input |
| core_d_i | input | NB | Core output values for bidirectional pads |
| core_oe_i | input | NB | Core output enables for bidirectional pads |
| pin_in_i | input | NB+NI | Pad input buffers: bidirectional pads first, then input-only pads |
| pin_d_o | output | NB | Value driven toward each bidirectional pad |
| pin_oe_o | output | NB | Output enable for each bidirectional pad |
| tdo_o | output | 1 | Serial scan output (last stage) |

## Verification
A stage that captures the wrong source, or that is linked in the wrong place, shows up at `tdo_o` as a wrong bit. That bit appears at the shift position that belongs to the affected stage, so it appears within 3*NB+NI shifts of the capture. A holding latch that is wrong, or that moves during a shift, shows up at once on `pin_d_o` or `pin_oe_o` in external test mode, on the first edge after the disturbance. A mode decode fault shows up in the same cycle as a pad enable that is on in high-impedance mode, or as core values that fail to pass through in functional mode.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    MODE_FUNC     = 2'b00,
    MODE_EXTEST   = 2'b01,
    MODE_HIGHZ    = 2'b10,
    MODE_FUNC_ALT = 2'b11
  } bsc_mode_e;

  localparam int STAGES_BIDIR = 3;
  localparam int STAGES_INPUT = 1;
endpackage

// File: rtl/bsc_bidir_cell.sv
module bsc_bidir_cell (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic si,
  input  logic core_d,
  input  logic core_oe,
  input  logic pin_in,
  output logic so,
  output logic hold_d,
  output logic hold_oe
);
  logic st_d, st_oe, st_in;

  // scan stages: capture has priority over shift
  always_ff @(posedge clk) begin
    if (rst) begin
      st_d  <= 1'b0;
      st_oe <= 1'b0;
      st_in <= 1'b0;
    end else if (cap_en) begin
      st_d  <= core_d;
      st_oe <= core_oe;
      st_in <= pin_in;
    end else if (shift_en) begin
      st_d  <= si;
      st_oe <= st_d;
      st_in <= st_oe;
    end
  end

  // holding latches for the pad driver
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_d  <= 1'b0;
      hold_oe <= 1'b0;
    end else if (upd_en) begin
      hold_d  <= st_d;
      hold_oe <= st_oe;
    end
  end

  assign so = st_in;
endmodule

// File: rtl/bsc_input_cell.sv
module bsc_input_cell (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_en,
  input  logic si,
  input  logic pin_in,
  output logic so
);
  logic st_in;

  always_ff @(posedge clk) begin
    if (rst)           st_in <= 1'b0;
    else if (cap_en)   st_in <= pin_in;
    else if (shift_en) st_in <= si;
  end

  assign so = st_in;
endmodule

// File: rtl/bsc_drive_sel.sv
module bsc_drive_sel
  import bsc_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic [1:0]    mode,
  input  logic [NB-1:0] core_d,
  input  logic [NB-1:0] core_oe,
  input  logic [NB-1:0] hold_d,
  input  logic [NB-1:0] hold_oe,
  output logic [NB-1:0] pin_d,
  output logic [NB-1:0] pin_oe
);
  bsc_mode_e mode_e;
  assign mode_e = bsc_mode_e'(mode);

  always_comb begin
    unique case (mode_e)
      MODE_EXTEST: begin
        pin_d  = hold_d;
        pin_oe = hold_oe;
      end
      MODE_HIGHZ: begin
        pin_d  = core_d;
        pin_oe = '0;
      end
      default: begin
        pin_d  = core_d;
        pin_oe = core_oe;
      end
    endcase
  end
endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
  import bsc_pkg::*;
#(
  parameter int NB = 4,
  parameter int NI = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic             shift_en,
  input  logic             upd_en,
  input  logic [1:0]       mode_i,
  input  logic             tdi_i,
  input  logic [NB-1:0]    core_d_i,
  input  logic [NB-1:0]    core_oe_i,
  input  logic [NB+NI-1:0] pin_in_i,
  output logic [NB-1:0]    pin_d_o,
  output logic [NB-1:0]    pin_oe_o,
  output logic             tdo_o
);
  localparam int NP        = NB + NI;
  localparam int CHAIN_LEN = STAGES_BIDIR * NB + STAGES_INPUT * NI;

  // serial link between cells: link[0] is TDI, link[NP] is TDO
  logic [NP:0]   link;
  logic [NB-1:0] hold_d, hold_oe;

  assign link[0] = tdi_i;

  genvar k;
  generate
    for (k = 0; k < NB; k++) begin : g_bidir
      bsc_bidir_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .upd_en   (upd_en),
        .si       (link[k]),
        .core_d   (core_d_i[k]),
        .core_oe  (core_oe_i[k]),
        .pin_in   (pin_in_i[k]),
        .so       (link[k+1]),
        .hold_d   (hold_d[k]),
        .hold_oe  (hold_oe[k])
      );
    end
    for (k = NB; k < NP; k++) begin : g_inonly
      bsc_input_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .si       (link[k]),
        .pin_in   (pin_in_i[k]),
        .so       (link[k+1])
      );
    end
  endgenerate

  assign tdo_o = link[NP];

  bsc_drive_sel #(.NB(NB)) u_drive (
    .mode    (mode_i),
    .core_d  (core_d_i),
    .core_oe (core_oe_i),
    .hold_d  (hold_d),
    .hold_oe (hold_oe),
    .pin_d   (pin_d_o),
    .pin_oe  (pin_oe_o)
  );

  initial begin
    if (CHAIN_LEN < 1 || NB < 1) $error("bsc_chain: needs at least one bidirectional pad");
  end
endmodule

// File: rtl/bsc_chain_chk.sv
module bsc_chain_chk #(
  parameter int NB = 4,
  parameter int NI = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cap_en,
  input logic             shift_en,
  input logic             upd_en,
  input logic [1:0]       mode_i,
  input logic [NB-1:0]    core_d_i,
  input logic [NB-1:0]    core_oe_i,
  input logic [NB+NI-1:0] pin_in_i,
  input logic [NB-1:0]    pin_d_o,
  input logic [NB-1:0]    pin_oe_o,
  input logic             tdo_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (tdo_o == 1'b0) && (mode_i != 2'b01 || (pin_oe_o == '0 && pin_d_o == '0))); // R1

  AST_CAPTURE_LAST: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> tdo_o == $past(pin_in_i[NB+NI-1])); // R2

  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (rst)
    (cap_en && shift_en) |=> tdo_o == $past(pin_in_i[NB+NI-1])); // R9

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b01 && !upd_en) |=> (mode_i != 2'b01) || ($stable(pin_d_o) && $stable(pin_oe_o))); // R4

  AST_HIGHZ_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b10) |-> (pin_oe_o == '0)); // R6

  AST_FUNC_PASS: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00 || mode_i == 2'b11) |-> (pin_d_o == core_d_i && pin_oe_o == core_oe_i)); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !shift_en) |=> $stable(tdo_o)); // R8
endmodule

bind bsc_chain bsc_chain_chk #(.NB(NB), .NI(NI)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cap_en    (cap_en),
  .shift_en  (shift_en),
  .upd_en    (upd_en),
  .mode_i    (mode_i),
  .core_d_i  (core_d_i),
  .core_oe_i (core_oe_i),
  .pin_in_i  (pin_in_i),
  .pin_d_o   (pin_d_o),
  .pin_oe_o  (pin_oe_o),
  .tdo_o     (tdo_o)
);

// File: tb/bsc_chain_tb_top.sv
module bsc_chain_tb_top;
  localparam int NB = 4;
  localparam int NI = 1;
  localparam int NP = NB + NI;
  localparam int L  = 3 * NB + NI;
  localparam logic [1:0] M_FUNC = 2'b00, M_EXT = 2'b01, M_HIZ = 2'b10, M_ALT = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, tdi = 1'b0;
  logic [1:0] mode = M_FUNC;
  logic [NB-1:0] core_d = '0, core_oe = '0;
  logic [NP-1:0] pin_in = '0;
  logic [NB-1:0] pin_d, pin_oe;
  logic tdo;

  logic [L-1:0]  exp_sr = '0;
  logic [NB-1:0] exp_hd = '0, exp_ho = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bsc_chain #(.NB(NB), .NI(NI)) dut_i (
    .clk(clk), .rst(rst), .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
    .mode_i(mode), .tdi_i(tdi), .core_d_i(core_d), .core_oe_i(core_oe),
    .pin_in_i(pin_in), .pin_d_o(pin_d), .pin_oe_o(pin_oe), .tdo_o(tdo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // one clock edge, then sample 5 ns later (away from both edges)
  task automatic cyc();
    @(posedge clk);
    #5;
  endtask

  task automatic model_capture();
    for (int k = 0; k < NB; k++) begin
      exp_sr[L-1-3*k] = core_d[k];
      exp_sr[L-2-3*k] = core_oe[k];
      exp_sr[L-3-3*k] = pin_in[k];
    end
    for (int j = 0; j < NI; j++) exp_sr[L-1-3*NB-j] = pin_in[NB+j];
  endtask

  task automatic do_capture();
    cap_en = 1'b1; cyc(); cap_en = 1'b0;
    model_capture();
  endtask

  task automatic do_shift(input logic b);
    shift_en = 1'b1; tdi = b; cyc(); shift_en = 1'b0;
    exp_sr = {b, exp_sr[L-1:1]};
  endtask

  task automatic do_update();
    upd_en = 1'b1; cyc(); upd_en = 1'b0;
    for (int k = 0; k < NB; k++) begin
      exp_hd[k] = exp_sr[L-1-3*k];
      exp_ho[k] = exp_sr[L-2-3*k];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #5;
    mode = M_EXT;
    core_d = '1; core_oe = '1;
    repeat (3) cyc();
    rst = 1'b0;
    // R1: reset state
    check("R1 tdo", {31'b0, tdo}, 32'h0);
    check("R1 pin_oe", {28'b0, pin_oe}, 32'h0);
    check("R1 pin_d", {28'b0, pin_d}, 32'h0);

    // R2/R3: capture patterns and shift them out
    mode = M_FUNC;
    for (int p = 0; p < 32; p++) begin
      core_d  = p[3:0];
      core_oe = p[3:0] ^ {4{p[4]}} ^ 4'b0110;
      pin_in  = 5'((p * 7 + 3) % 32);
      do_capture();
      check("R2 capture last stage", {31'b0, tdo}, {31'b0, exp_sr[0]});
      for (int s = 0; s < L; s++) begin
        do_shift(p[s % 5]);
        check("R3 shift out", {31'b0, tdo}, {31'b0, exp_sr[0]});
      end
    end

    // R3: chain length - a lone 1 reaches tdo after exactly L shifts
    core_d = '0; core_oe = '0; pin_in = '0;
    do_capture();
    begin
      int seen = -1;
      for (int s = 1; s <= L + 2; s++) begin
        do_shift(s == 1);
        if (tdo && seen < 0) seen = s;
      end
      check("R3 chain length", seen, L);
    end

    // R4/R5: exhaustive sweep of holding latch contents in external test mode
    mode = M_EXT;
    for (int v = 0; v < 256; v++) begin
      logic [L-1:0] tgt;
      tgt = '0;
      for (int k = 0; k < NB; k++) begin
        tgt[L-1-3*k] = v[k];
        tgt[L-2-3*k] = v[4+k];
      end
      core_d = ~v[3:0]; core_oe = v[7:4] ^ 4'b1010;
      for (int s = 0; s < L; s++) begin
        do_shift(tgt[s]);
        check("R3 shift in", {31'b0, tdo}, {31'b0, exp_sr[0]});
        check("R4 hold stable during shift", {24'b0, pin_oe, pin_d}, {24'b0, exp_ho, exp_hd});
      end
      do_update();
      check("R5 extest value", {28'b0, pin_d}, {28'b0, v[3:0]});
      check("R5 extest enable", {28'b0, pin_oe}, {28'b0, v[7:4]});
    end
    // R4: capture leaves holds alone
    core_d = 4'b0101; core_oe = 4'b0000; pin_in = '1;
    do_capture();
    check("R4 hold stable after capture", {24'b0, pin_oe, pin_d}, {24'b0, exp_ho, exp_hd});

    // R6: high impedance forces enables off (holds currently all enabled)
    mode = M_HIZ;
    for (int v = 0; v < 256; v++) begin
      core_d = v[3:0]; core_oe = v[7:4];
      #1;
      check("R6 highz enable", {28'b0, pin_oe}, 32'h0);
    end

    // R7: functional modes pass core signals through
    for (int m = 0; m < 2; m++) begin
      mode = (m == 0) ? M_FUNC : M_ALT;
      for (int v = 0; v < 256; v++) begin
        core_d = v[3:0]; core_oe = v[7:4];
        #1;
        check("R7 pass value", {28'b0, pin_d}, {28'b0, v[3:0]});
        check("R7 pass enable", {28'b0, pin_oe}, {28'b0, v[7:4]});
      end
    end

    // R8: idle cycles keep chain contents while other inputs toggle
    mode = M_FUNC;
    core_d = 4'b1001; core_oe = 4'b0110; pin_in = 5'b10110;
    do_capture();
    for (int i = 0; i < 6; i++) begin
      core_d = ~core_d; pin_in = ~pin_in; tdi = ~tdi; upd_en = i[0];
      cyc();
      upd_en = 1'b0;
      check("R8 idle tdo", {31'b0, tdo}, {31'b0, exp_sr[0]});
    end
    for (int s = 0; s < L; s++) begin
      do_shift(1'b0);
      check("R8 idle content", {31'b0, tdo}, {31'b0, exp_sr[0]});
    end

    // R9: capture and shift together -> capture wins
    for (int p = 0; p < 4; p++) begin
      core_d = 4'(p); core_oe = 4'(~p); pin_in = 5'(p * 9);
      cap_en = 1'b1; shift_en = 1'b1; tdi = 1'b1;
      cyc();
      cap_en = 1'b0; shift_en = 1'b0;
      model_capture();
      check("R9 capture priority tdo", {31'b0, tdo}, {31'b0, exp_sr[0]});
      for (int s = 0; s < L; s++) begin
        do_shift(1'b0);
        check("R9 capture priority content", {31'b0, tdo}, {31'b0, exp_sr[0]});
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule